// File: doc/BRIEF.md
# Scratchpad Write Buffer with Transfer Status

This block is the staging side of a serial EEPROM's write path. A master opens a write session by loading a 16-bit target address. It then shifts data in one bit at a time, least significant bit first. Each completed byte is placed in a 32-byte scratchpad page. Placement begins at the byte offset given by the address's low five bits and moves upward. It stops at the top of the page and never wraps.

A status byte records three things:
- the offset of the last byte that was stored;
- a partial-data flag, which is resolved when the master strobes end-of-write;
- an authorization flag, which any new session clears.

The master reads the two address bytes, the status byte and any scratchpad byte through one read mux. The block has no write path into the status byte. Command decoding, the serial physical layer and the copy into the EEPROM array sit outside this block.

Top module: `scratch_stage`

## Requirements
- R1: After reset, the target low byte and high byte read 00h and the status byte reads 20h: the partial flag (bit 5) is set, and every other bit is clear.
- R2: A cycle with `addr_load` high captures `addr_in[7:0]` as the target low byte and `addr_in[15:8]` as the target high byte, and opens a write session. Both bytes read back the cycle after.
- R3: Inside a session, each `bit_valid` cycle shifts in `bit_in`, least significant bit first. Every eighth bit completes a byte. That byte is stored at the current write offset, and the offset then advances by one. The first write offset is `addr_in[4:0]`.
- R4: Status bits 4:0 hold the scratchpad offset of the most recently stored byte. They update on the same edge that stores it.
- R5: Once offset 31 has been stored, further complete bytes in the same session are discarded. Status bits 4:0 stay at 31, and scratchpad offsets below the start offset are not touched.
- R6: An `wr_end` strobe inside a session closes the session. It sets status bit 5 when the number of bits received in the session is not a multiple of 8, and clears bit 5 otherwise.
- R7: Status bit 6 always reads 0. A `bit_valid` outside a session, or an `wr_end` outside a session, changes neither the scratchpad nor the status byte.
- R8: `auth_set` sets status bit 7, and `addr_load` clears it. When both occur in the same cycle, the clear wins.
- R9: A `bit_valid` in the same cycle as `addr_load` or `wr_end` is dropped and not counted.
- R10: `rd_sel` selects the read data as follows: 0 gives the target low byte, 1 the target high byte, 2 the status byte, and 3 the scratchpad byte at `sp_raddr`. The read is combinational from stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also marks the scratchpad invalid |
| addr_load | input | 1 | Load target address and open a write session |
| addr_in | input | 16 | Target address to load |
| bit_valid | input | 1 | One serial data bit is present this cycle |
| bit_in | input | 1 | Serial data bit, least significant first |
| wr_end | input | 1 | End-of-write strobe |
| auth_set | input | 1 | Set the authorization flag in the status byte |
| rd_sel | input | 2 | Read source select |
| sp_raddr | input | 5 | Scratchpad offset for `rd_sel` = 3 |
| rd_data | output | 8 | Read data |

## Verification
Every stored result is due on the clock edge that samples the stimulus, and it reads back on the following falling edge, because the read mux adds no register. This applies to:
- a captured address;
- a stored byte and its ending offset;
- the partial flag after `wr_end`;
- the authorization flag.

The bench drives inputs shortly after each falling edge, so a behavioural model and the design both act on the same rising edge. At the next falling edge it reads the two address bytes, the status byte and one scratchpad byte, which it rotates through all 32 offsets, and compares them with the model. Directed checks on fixed expected values follow each scenario at the same sampling point.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned PAGE_BYTES = 32;
  localparam int unsigned OFF_W      = $clog2(PAGE_BYTES);
  localparam int unsigned ADDR_W     = 2 * BYTE_W;
  localparam int unsigned BCNT_W     = $clog2(BYTE_W);

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [OFF_W-1:0]  off_t;

  typedef enum logic [1:0] {
    SEL_TA_LO  = 2'd0,
    SEL_TA_HI  = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_SPAD   = 2'd3
  } rd_sel_e;

  // Status byte layout: [7] auth, [6] zero, [5] partial, [4:0] ending offset.
  function automatic byte_t pack_status(input logic auth, input logic partial,
                                        input off_t end_off);
    return {auth, 1'b0, partial, end_off};
  endfunction

  // Shift a new bit into the top of an LSB-first accumulator.
  function automatic byte_t shift_lsb_first(input byte_t acc, input logic b);
    return {b, acc[BYTE_W-1:1]};
  endfunction

  function automatic logic is_page_top(input off_t ptr);
    return ptr == off_t'(PAGE_BYTES - 1);
  endfunction
endpackage

// File: rtl/scp_bit_asm.sv
module scp_bit_asm
  import scp_pkg::*;
#(
  parameter int unsigned W  = BYTE_W,
  localparam int unsigned CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          take,
  input  logic          bit_in,
  output logic          byte_done,
  output logic [W-1:0]  byte_val,
  output logic [CW-1:0] bit_cnt
);
  logic [W-1:0] sh_q;

  assign byte_done = take && (bit_cnt == CW'(W - 1));
  assign byte_val  = {bit_in, sh_q[W-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q    <= '0;
      bit_cnt <= '0;
    end else if (clear) begin
      sh_q    <= '0;
      bit_cnt <= '0;
    end else if (take) begin
      sh_q    <= byte_val;
      bit_cnt <= byte_done ? '0 : bit_cnt + CW'(1);
    end
  end
endmodule

// File: rtl/scp_store.sv
module scp_store
  import scp_pkg::*;
#(
  parameter int unsigned DEPTH = PAGE_BYTES,
  parameter int unsigned DW    = BYTE_W,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] start_off,
  input  logic          byte_done,
  input  logic [DW-1:0] byte_val,
  input  logic [AW-1:0] sp_raddr,
  output logic [DW-1:0] sp_rdata,
  output logic [AW-1:0] end_off,
  output logic [AW-1:0] wr_ptr,
  output logic          full,
  output logic          store_we
);
  logic [DW-1:0] mem_q [DEPTH];

  assign store_we = byte_done && !full;
  assign sp_rdata = mem_q[sp_raddr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      full    <= 1'b0;
      end_off <= '0;
    end else if (load) begin
      wr_ptr <= start_off;
      full   <= 1'b0;
    end else if (store_we) begin
      end_off <= wr_ptr;
      if (wr_ptr == AW'(DEPTH - 1)) full <= 1'b1;
      else                          wr_ptr <= wr_ptr + AW'(1);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n)                                mem_q[g] <= '0;
      else if (store_we && wr_ptr == AW'(g))     mem_q[g] <= byte_val;
    end
  end
endmodule

// File: rtl/scp_status.sv
module scp_status
  import scp_pkg::*;
#(
  parameter int unsigned AW_T = ADDR_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            addr_load,
  input  logic [AW_T-1:0] addr_in,
  input  logic            wr_end,
  input  logic            auth_set,
  input  logic            partial_bits,
  output logic [AW_T-1:0] ta_q,
  output logic            active,
  output logic            pf_q,
  output logic            auth_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ta_q   <= '0;
      active <= 1'b0;
      pf_q   <= 1'b1;
      auth_q <= 1'b0;
    end else begin
      if (addr_load) begin
        ta_q   <= addr_in;
        active <= 1'b1;
      end else if (wr_end && active) begin
        pf_q   <= partial_bits;
        active <= 1'b0;
      end
      if (addr_load)     auth_q <= 1'b0;
      else if (auth_set) auth_q <= 1'b1;
    end
  end
endmodule

// File: rtl/scratch_stage.sv
module scratch_stage
  import scp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              bit_valid,
  input  logic              bit_in,
  input  logic              wr_end,
  input  logic              auth_set,
  input  logic [1:0]        rd_sel,
  input  logic [OFF_W-1:0]  sp_raddr,
  output logic [BYTE_W-1:0] rd_data
);
  logic [ADDR_W-1:0] ta_q;
  logic              active, pf_q, auth_q;
  logic              take, byte_done, full, store_we;
  byte_t             byte_val, sp_rdata, es_q;
  logic [BCNT_W-1:0] bit_cnt;
  off_t              end_off, wr_ptr;

  assign take = bit_valid && active && !addr_load && !wr_end;

  scp_bit_asm #(.W(BYTE_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .clear(addr_load), .take(take), .bit_in(bit_in),
    .byte_done(byte_done), .byte_val(byte_val), .bit_cnt(bit_cnt)
  );

  scp_store #(.DEPTH(PAGE_BYTES), .DW(BYTE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .load(addr_load), .start_off(addr_in[OFF_W-1:0]),
    .byte_done(byte_done), .byte_val(byte_val), .sp_raddr(sp_raddr),
    .sp_rdata(sp_rdata), .end_off(end_off), .wr_ptr(wr_ptr), .full(full),
    .store_we(store_we)
  );

  scp_status #(.AW_T(ADDR_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .wr_end(wr_end), .auth_set(auth_set), .partial_bits(bit_cnt != '0),
    .ta_q(ta_q), .active(active), .pf_q(pf_q), .auth_q(auth_q)
  );

  assign es_q = pack_status(auth_q, pf_q, end_off);

  always_comb begin
    unique case (rd_sel_e'(rd_sel))
      SEL_TA_LO:  rd_data = ta_q[BYTE_W-1:0];
      SEL_TA_HI:  rd_data = ta_q[ADDR_W-1:BYTE_W];
      SEL_STATUS: rd_data = es_q;
      default:    rd_data = sp_rdata;
    endcase
  end
endmodule

// File: rtl/scp_checker.sv
module scp_checker
  import scp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              addr_load,
  input logic [ADDR_W-1:0] addr_in,
  input logic              bit_valid,
  input logic              wr_end,
  input logic              active,
  input logic [BCNT_W-1:0] bit_cnt,
  input logic              full,
  input logic              byte_done,
  input logic              store_we,
  input logic [OFF_W-1:0]  wr_ptr,
  input logic [ADDR_W-1:0] ta_q,
  input logic [BYTE_W-1:0] es_q
);
  p_bit6_zero_r7: assert property (@(posedge clk) disable iff (!rst_n) es_q[6] == 1'b0);

  p_ta_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_load |=> ta_q == $past(addr_in));

  p_auth_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_load |=> !es_q[7]);

  p_whole_clears_pf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_end && !addr_load && active && bit_cnt == '0) |=> !es_q[5]);

  p_partial_sets_pf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_end && !addr_load && active && bit_cnt != '0) |=> es_q[5]);

  p_store_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    store_we |=> es_q[OFF_W-1:0] == $past(wr_ptr));

  p_full_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && byte_done) |=> es_q[OFF_W-1:0] == OFF_W'(PAGE_BYTES - 1));

  p_idle_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !active && !addr_load) |=> $stable(bit_cnt) && $stable(es_q[OFF_W-1:0]));

  p_drop_on_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && wr_end && !addr_load) |=> $stable(bit_cnt));
endmodule

bind scratch_stage scp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
  .bit_valid(bit_valid), .wr_end(wr_end), .active(active), .bit_cnt(bit_cnt),
  .full(full), .byte_done(byte_done), .store_we(store_we), .wr_ptr(wr_ptr),
  .ta_q(ta_q), .es_q(es_q)
);

// File: tb/scratch_stage_tb.sv
`timescale 1ns/10ps
module scratch_stage_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_load = 1'b0;
  logic [15:0] addr_in = '0;
  logic        bit_valid = 1'b0;
  logic        bit_in = 1'b0;
  logic        wr_end = 1'b0;
  logic        auth_set = 1'b0;
  logic [1:0]  rd_sel = '0;
  logic [4:0]  sp_raddr = '0;
  logic [7:0]  rd_data;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  scratch_stage dut_i (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .bit_valid(bit_valid), .bit_in(bit_in), .wr_end(wr_end), .auth_set(auth_set),
    .rd_sel(rd_sel), .sp_raddr(sp_raddr), .rd_data(rd_data)
  );

  // Behavioural reference model
  int         m_ta, m_end, m_bits, m_acc, m_ptr;
  bit         m_pf, m_aa, m_active, m_full;
  logic [7:0] m_mem [32];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ta = 0; m_end = 0; m_bits = 0; m_acc = 0; m_ptr = 0;
      m_pf = 1; m_aa = 0; m_active = 0; m_full = 0;
      for (int i = 0; i < 32; i++) m_mem[i] = 8'h00;
    end else begin
      if (auth_set) m_aa = 1;
      if (addr_load) begin
        m_ta = addr_in; m_active = 1; m_aa = 0; m_bits = 0; m_acc = 0;
        m_ptr = addr_in % 32; m_full = 0;
      end else if (wr_end) begin
        if (m_active) begin
          m_pf = (m_bits % 8) != 0;
          m_active = 0;
        end
      end else if (bit_valid && m_active) begin
        m_acc = m_acc + (int'(bit_in) << (m_bits % 8));
        m_bits++;
        if (m_bits % 8 == 0) begin
          if (!m_full) begin
            m_mem[m_ptr] = m_acc[7:0];
            m_end = m_ptr;
            if (m_ptr == 31) m_full = 1; else m_ptr++;
          end
          m_acc = 0;
        end
      end
    end
  end

  logic [7:0] obs_lo, obs_hi, obs_es, obs_sp;

  task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Per-cycle comparison on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      rd_sel = 2'd0; #0.1 obs_lo = rd_data;
      cmp("R2/R10 target low", obs_lo, m_ta[7:0]);
      rd_sel = 2'd1; #0.1 obs_hi = rd_data;
      cmp("R2/R10 target high", obs_hi, m_ta[15:8]);
      rd_sel = 2'd2; #0.1 obs_es = rd_data;
      cmp("R4/R6/R7/R8 status", obs_es, {m_aa, 1'b0, m_pf, 5'(m_end)});
      rd_sel = 2'd3; sp_raddr = 5'(cyc % 32); #0.1 obs_sp = rd_data;
      cmp("R3/R5 scratchpad", obs_sp, m_mem[cyc % 32]);
    end
  end

  task automatic step(input bit ld, input logic [15:0] a, input bit bv, input bit bi,
                      input bit we, input bit au);
    @(negedge clk); #1;
    addr_load = ld; addr_in = a; bit_valid = bv; bit_in = bi; wr_end = we; auth_set = au;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 16'h0, 0, 0, 0, 0);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) step(0, 16'h0, 1, b[i], 0, 0);
  endtask

  task automatic send_bits(input int n, input logic [7:0] b);
    for (int i = 0; i < n; i++) step(0, 16'h0, 1, b[i], 0, 0);
  endtask

  task automatic expect_es(input string tag, input logic [7:0] exp);
    idle(1);
    cmp(tag, obs_es, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    idle(1);
    cmp("R1 reset target low", obs_lo, 8'h00);
    cmp("R1 reset target high", obs_hi, 8'h00);
    cmp("R1 reset status", obs_es, 8'h20);

    // Start near the page top: four bytes fill it, two more are discarded
    step(1, 16'h003C, 0, 0, 0, 0);
    idle(1);
    cmp("R2 load low", obs_lo, 8'h3C);
    send_byte(8'hA1); send_byte(8'h5B);
    expect_es("R4 ending offset", 8'h3D);
    send_byte(8'hC3); send_byte(8'h96);
    expect_es("R5 page top reached", 8'h3F);
    send_byte(8'hEE); send_byte(8'h11);
    expect_es("R5 overflow discarded", 8'h3F);
    step(0, 16'h0, 0, 0, 1, 0);
    expect_es("R6 whole bytes clear flag", 8'h1F);
    idle(32);

    // Partial trailing byte, upper address byte
    step(1, 16'h0105, 0, 0, 0, 0);
    idle(1);
    cmp("R2 load high", obs_hi, 8'h01);
    send_byte(8'h3C); send_byte(8'h81); send_byte(8'h7E);
    send_bits(3, 8'h05);
    step(0, 16'h0, 0, 0, 1, 0);
    expect_es("R6 partial sets flag", 8'h27);

    // Bits and end strobe outside a session have no effect
    send_byte(8'hFF);
    step(0, 16'h0, 0, 0, 1, 0);
    expect_es("R7 idle bits ignored", 8'h27);
    idle(32);

    // Authorization flag: set, cleared by load, load wins on a tie
    step(0, 16'h0, 0, 0, 0, 1);
    expect_es("R8 auth set", 8'hA7);
    step(1, 16'h0210, 0, 0, 0, 1);
    expect_es("R8 load wins over auth", 8'h27);

    // Bit in the same cycle as the end strobe is dropped
    send_bits(7, 8'h55);
    step(0, 16'h0, 1, 1, 1, 0);
    expect_es("R9 bit with end dropped", 8'h27);

    // Bit in the same cycle as a load is dropped: 8 further bits make one byte
    step(1, 16'h0000, 1, 1, 0, 0);
    send_byte(8'h42);
    step(0, 16'h0, 0, 0, 1, 0);
    expect_es("R9 bit with load dropped", 8'h00);
    idle(40);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule